// File: doc/BRIEF.md
# Pulse-Event Interrupt Register Block

This block is an APB3 slave that gathers N single-cycle event pulses into per-source interrupt state and drives one combined interrupt line. Each source has four bits of state spread across four word registers. The first register latches events and is cleared by software writing ones to it. The second lets software force a source active for debug. The third masks sources, with a 1 meaning the source is off. The fourth is read-only and reports which sources are currently asserting.

The four registers sit at consecutive word addresses from a parameterised base. The addresses are 16 bits wide and the data is 32 bits wide. All masks come out of reset set, so no interrupt can reach the output until software opens it. The event inputs are synchronous to the bus clock.

Top module: `apb_irq_regs`

## Requirements
- R1: After reset the latch register and the force register read 0, the mask register reads all N low bits set, the status register reads 0, and `irq` is low.
- R2: An event pulse on `events[i]` sets latch bit i at the next rising clock edge. The bit stays set until software clears it.
- R3: A write to the latch register (offset 0x0) clears each bit that is 1 in the written data. Bits written 0 are left unchanged.
- R4: When an event pulse and a write-1 clear hit the same latch bit in the same cycle, the bit ends up set.
- R5: The force register (offset 0x4) is read-write and reads back the last value written, restricted to N bits.
- R6: The mask register (offset 0x8) is read-write. A mask bit of 1 blocks its source from the status register and from `irq`. A mask bit of 0 passes it.
- R7: Status bit i, read at offset 0xC, equals (latch[i] OR force[i]) AND NOT mask[i].
- R8: `irq` is high exactly when any status bit is 1. It follows register changes in the same cycle they become visible.
- R9: Writes to the status offset have no effect. Addresses other than base+0x0, 0x4, 0x8 and 0xC read as zero, and writes to them have no effect.
- R10: Read data bits N and above are always zero. `pready` is always 1 and `pslverr` is always 0, so every transfer is one setup cycle followed by one access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 16 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| events | input | N | One-cycle event pulses, one per source |
| irq | output | 1 | OR of all status bits |

## Verification
A write takes effect at the rising edge that ends its access phase. An event pulse held for one cycle lands in the latch at the edge at the end of that cycle. The bench therefore updates its model at those same edges and samples registers and `irq` only from the following falling edge. Read data is combinational during the access phase, so the bench samples `prdata` shortly after driving `penable`, before the edge that closes the transfer. Random streams of pulses, writes and reads are compared against a bench model throughout, alongside directed cases for the simultaneous set-and-clear and the unmapped and status-write paths.

// File: rtl/apb_irq_regs.sv
module apb_irq_regs #(
  parameter int N = 8,
  parameter logic [15:0] BASE = 16'h0000
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [15:0]   paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic [N-1:0]  events,
  output logic          irq
);
  localparam logic [31:0] VALID = 32'((64'd1 << N) - 64'd1);
  localparam logic [15:0] A_RAW = BASE;
  localparam logic [15:0] A_FRC = BASE + 16'h4;
  localparam logic [15:0] A_MSK = BASE + 16'h8;
  localparam logic [15:0] A_STS = BASE + 16'hC;

  logic [31:0] raw_q, force_q, mask_q, evt_w, status_w;
  logic        wr;

  assign evt_w    = 32'(events);
  assign wr       = psel & penable & pwrite;
  assign status_w = (raw_q | force_q) & ~mask_q;
  assign irq      = |status_w;
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;

  always_ff @(posedge pclk) begin
    if (!presetn) begin
      raw_q   <= '0;
      force_q <= '0;
      mask_q  <= VALID;
    end else begin
      raw_q <= (((wr && paddr == A_RAW) ? (raw_q & ~pwdata) : raw_q) | evt_w) & VALID;
      if (wr && paddr == A_FRC) force_q <= pwdata & VALID;
      if (wr && paddr == A_MSK) mask_q  <= pwdata & VALID;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        A_RAW:   prdata = raw_q;
        A_FRC:   prdata = force_q;
        A_MSK:   prdata = mask_q;
        A_STS:   prdata = status_w;
        default: prdata = '0;
      endcase
    end
  end
endmodule

module apb_irq_regs_chk #(
  parameter int N = 8,
  parameter logic [15:0] BASE = 16'h0000
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [15:0]   paddr,
  input logic [31:0]   prdata,
  input logic          pready,
  input logic          pslverr,
  input logic [N-1:0]  events,
  input logic          irq,
  input logic [31:0]   raw_q,
  input logic [31:0]   force_q,
  input logic [31:0]   mask_q
);
  localparam logic [31:0] VALID = 32'((64'd1 << N) - 64'd1);
  logic [31:0] evt32;
  assign evt32 = 32'(events);

  assert_evt_sets_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (|events) |=> ((raw_q & $past(evt32)) == $past(evt32)));

  assert_no_spurious_set_R2: assert property (@(posedge pclk) disable iff (!presetn)
    presetn |=> ((raw_q & ~$past(raw_q) & ~$past(evt32)) == 32'd0));

  assert_masked_quiet_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (mask_q == VALID) |-> !irq);

  assert_idle_quiet_R8: assert property (@(posedge pclk) disable iff (!presetn)
    (raw_q == 32'd0 && force_q == 32'd0) |-> !irq);

  assert_sts_write_ignored_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == BASE + 16'hC) |=> ($stable(mask_q) && $stable(force_q)));

  assert_handshake_R10: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  assert_upper_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> ((prdata & ~VALID) == 32'd0));
endmodule

bind apb_irq_regs apb_irq_regs_chk #(.N(N), .BASE(BASE)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .events(events), .irq(irq), .raw_q(raw_q), .force_q(force_q), .mask_q(mask_q)
);

// File: tb/tb_apb_irq_regs.sv
module tb_apb_irq_regs;
  localparam int N = 5;
  localparam logic [15:0] BASE = 16'h0040;
  localparam logic [31:0] VM = 32'h1F;

  logic pclk = 0, presetn = 0, psel = 0, penable = 0, pwrite = 0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, irq;
  logic [N-1:0] events = '0;

  int checks = 0, errors = 0;
  logic [31:0] m_raw = 0, m_frc = 0, m_msk = VM;

  always #2 pclk = ~pclk;

  apb_irq_regs #(.N(N), .BASE(BASE)) dut (.*);

  function automatic logic [31:0] f_status();
    return (m_raw | m_frc) & ~m_msk;
  endfunction

  function automatic logic [31:0] f_read(logic [15:0] a);
    if (a == BASE)        return m_raw;
    if (a == BASE + 16'h4) return m_frc;
    if (a == BASE + 16'h8) return m_msk;
    if (a == BASE + 16'hC) return f_status();
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [15:0] a, logic [31:0] d, logic [N-1:0] evt);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk);
    penable = 1; events = evt;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0; events = '0;
    if (a == BASE)         m_raw = (m_raw & ~d) & VM;
    else if (a == BASE + 16'h4) m_frc = d & VM;
    else if (a == BASE + 16'h8) m_msk = d & VM;
    m_raw = (m_raw | 32'(evt)) & VM;
  endtask

  task automatic apb_read(logic [15:0] a, string req);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk);
    penable = 1;
    #1;
    chk(req, prdata, f_read(a));
    chk("R10 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic pulse(logic [N-1:0] evt);
    @(negedge pclk);
    events = evt;
    @(negedge pclk);
    events = '0;
    m_raw = (m_raw | 32'(evt)) & VM;
    chk("R8 irq", {31'd0, irq}, {31'd0, |f_status()});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    apb_read(BASE,          "R1 raw reset");
    apb_read(BASE + 16'h4,  "R1 force reset");
    apb_read(BASE + 16'h8,  "R1 mask reset");
    apb_read(BASE + 16'hC,  "R1 status reset");
    chk("R1 irq reset", {31'd0, irq}, 32'd0);

    pulse(5'b00101);
    apb_read(BASE, "R2 raw latched");
    chk("R6 masked irq low", {31'd0, irq}, 32'd0);
    apb_write(BASE, 32'h4, '0);
    apb_read(BASE, "R3 w1c partial");
    apb_write(BASE, 32'h1, 5'b00001);
    apb_read(BASE, "R4 set wins over clear");
    apb_write(BASE + 16'h4, 32'hFFFF_FFF2, '0);
    apb_read(BASE + 16'h4, "R5 force readback");
    apb_write(BASE + 16'h8, 32'h0000_0016, '0);
    apb_read(BASE + 16'hC, "R7 status");
    chk("R8 irq on", {31'd0, irq}, {31'd0, |f_status()});
    apb_write(BASE + 16'hC, 32'h0, '0);
    apb_read(BASE + 16'h8, "R9 status write ignored mask");
    apb_read(BASE + 16'h4, "R9 status write ignored force");
    apb_write(BASE + 16'h10, 32'hFFFF_FFFF, '0);
    apb_read(BASE + 16'h10, "R9 unmapped reads zero");
    apb_read(BASE + 16'h8,  "R9 unmapped write ignored");
    apb_write(BASE + 16'h8, 32'hFFFF_FFFF, '0);
    apb_read(BASE + 16'h8, "R10 upper bits zero");

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [15:0] a;
      op = $urandom_range(0, 3);
      a = BASE + 16'(4 * $urandom_range(0, 4));
      case (op)
        0: pulse(N'($urandom));
        1: apb_write(a, $urandom, N'($urandom_range(0, 3) == 0 ? $urandom : 0));
        default: apb_read(a, "R7 random readback");
      endcase
      chk("R8 irq random", {31'd0, irq}, {31'd0, |f_status()});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule